// File: doc/BRIEF.md
# AXI Address Decoder with Default Slave

This block sits between one AXI manager port and a set of subordinate ports. Every write and read request address is checked against a table of regions. Each region is given as a base and a size. The request valid goes only to the port whose region holds the address. The address, length, write data and strobes are broadcast to all ports, and only the valid is steered. The decoder allows one outstanding transaction in each direction. The write and read paths run independently of each other.

An address that falls in no region goes to a default responder built into the block. For a write, the responder accepts the address and every data beat, then returns a single decode-error response. For a read, it returns the full burst of zero data, with a decode error on every beat. A read burst that starts in a region but runs past that region's end is also handled. Every beat at or beyond the end is turned into a decode error with zero data, whatever the subordinate returns. Bursts are incrementing, with one data-bus width per beat.

The chosen region index for the current or last transaction is visible on two debug outputs, one per direction.

Top module: `axi_addr_decoder`

## Requirements
- R1: A request whose address satisfies base <= addr < base + size for some region raises the valid of that port only. No other port sees a valid. Address, length, data, strobe and last are broadcast unchanged to all ports.
- R2: When regions overlap, the region with the lowest index takes the request.
- R3: An unmapped write is accepted by the default responder, which holds wready high for every W beat. In the cycle after the WLAST handshake it raises bvalid with BRESP = 2'b11 and holds it until bready.
- R4: An unmapped read returns ARLEN+1 beats of all-zero data with RRESP = 2'b11. RLAST is set on the final beat only. The first beat is valid in the cycle after the AR handshake, and no beat follows the last one.
- R5: For a mapped read, beat i has the address ARADDR + i*(DW/8). A beat whose address reaches or passes the end of the selected region reports RRESP = 2'b11 with zero data. Earlier beats carry the subordinate's data and response unchanged.
- R6: For a mapped write, the selected port's BRESP and bvalid reach the manager unchanged, including an error code such as 2'b10.
- R7: From the cycle after an address handshake, wr_dec_idx (for writes) or rd_dec_idx (for reads) shows the chosen region index, or NSLV for the default responder. The value holds until the next handshake in that direction.
- R8: awready stays low from the AW handshake until the B handshake completes. arready stays low from the AR handshake until the final R beat is taken.
- R9: After reset, s_bvalid, s_rvalid, m_awvalid and m_arvalid are low.
- R10: While a default-responder read beat waits with rready low, s_rvalid, s_rdata, s_rresp and s_rlast hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_awaddr | input | AW | Manager write address |
| s_awlen | input | LW | Manager write burst length minus one |
| s_awvalid | input | 1 | Manager write address valid |
| s_awready | output | 1 | Write address ready to manager |
| s_wdata | input | DW | Manager write data |
| s_wstrb | input | DW/8 | Manager write strobes |
| s_wlast | input | 1 | Manager last write beat |
| s_wvalid | input | 1 | Manager write data valid |
| s_wready | output | 1 | Write data ready to manager |
| s_bresp | output | 2 | Write response to manager |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Manager write response ready |
| s_araddr | input | AW | Manager read address |
| s_arlen | input | LW | Manager read burst length minus one |
| s_arvalid | input | 1 | Manager read address valid |
| s_arready | output | 1 | Read address ready to manager |
| s_rdata | output | DW | Read data to manager |
| s_rresp | output | 2 | Per-beat read response to manager |
| s_rlast | output | 1 | Last read beat |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Manager read data ready |
| m_awaddr | output | AW | Broadcast write address |
| m_awlen | output | LW | Broadcast write length |
| m_awvalid | output | NSLV | Per-port write address valid |
| m_awready | input | NSLV | Per-port write address ready |
| m_wdata | output | DW | Broadcast write data |
| m_wstrb | output | DW/8 | Broadcast write strobes |
| m_wlast | output | 1 | Broadcast last write beat |
| m_wvalid | output | NSLV | Per-port write data valid |
| m_wready | input | NSLV | Per-port write data ready |
| m_bresp | input | 2*NSLV | Per-port write responses |
| m_bvalid | input | NSLV | Per-port write response valid |
| m_bready | output | NSLV | Per-port write response ready |
| m_araddr | output | AW | Broadcast read address |
| m_arlen | output | LW | Broadcast read length |
| m_arvalid | output | NSLV | Per-port read address valid |
| m_arready | input | NSLV | Per-port read address ready |
| m_rdata | input | DW*NSLV | Per-port read data |
| m_rresp | input | 2*NSLV | Per-port read responses |
| m_rlast | input | NSLV | Per-port last read beat |
| m_rvalid | input | NSLV | Per-port read data valid |
| m_rready | output | NSLV | Per-port read data ready |
| wr_dec_idx | output | $clog2(NSLV+1) | Chosen write target, NSLV for default |
| rd_dec_idx | output | $clog2(NSLV+1) | Chosen read target, NSLV for default |

## Verification
Routing is combinational, so the bench checks each port's valid against its own region lookup in the same cycle as the manager's request, on every clock. The debug index and the dropped awready/arready are due one cycle after the address handshake. Default write responses and the first read beat are due one cycle after the WLAST or AR handshake. Each later read beat is due one cycle after the previous beat's handshake. The tasks sample at a fixed offset after the falling edge that follows each handshake edge, so every check reads the value the design registered at exactly that edge. The bench predicts each beat's response code and data from the beat address and the region table, not from the design.

// File: rtl/axdec_pkg.sv
package axdec_pkg;
  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_DECERR = 2'b11;

  typedef enum logic [1:0] {WR_IDLE, WR_DATA, WR_RESP} wr_state_e;
  typedef enum logic       {RD_IDLE, RD_DATA}          rd_state_e;
endpackage

// File: rtl/axdec_region_match.sv
module axdec_region_match #(
  parameter int NSLV = 2,
  parameter int AW   = 16,
  parameter int IW   = $clog2(NSLV + 1),
  parameter logic [NSLV*AW-1:0] BASES = '0,
  parameter logic [NSLV*AW-1:0] SIZES = '0
) (
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic [IW-1:0] idx,
  output logic [AW:0]   lim
);
  logic [NSLV-1:0] inr;
  logic [AW:0]     ends [NSLV];
  logic [AW:0]     addr_x;

  assign addr_x = {1'b0, addr};

  // one comparator pair per region; end kept one bit wider to avoid wrap
  for (genvar g = 0; g < NSLV; g++) begin : g_rgn
    localparam logic [AW:0] BASE_X = {1'b0, BASES[g*AW +: AW]};
    localparam logic [AW:0] SIZE_X = {1'b0, SIZES[g*AW +: AW]};
    assign ends[g] = BASE_X + SIZE_X;
    assign inr[g]  = (addr_x >= BASE_X) && (addr_x < ends[g]);
  end

  // priority pick: scanning downwards leaves the lowest matching index
  always_comb begin
    hit = |inr;
    idx = IW'(NSLV);
    lim = '0;
    for (int k = NSLV - 1; k >= 0; k--) begin
      if (inr[k]) begin
        idx = IW'(k);
        lim = ends[k];
      end
    end
  end
endmodule

// File: rtl/axdec_wr_path.sv
module axdec_wr_path
  import axdec_pkg::*;
#(
  parameter int NSLV = 2,
  parameter int AW   = 16,
  parameter int IW   = $clog2(NSLV + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     s_awaddr,
  input  logic              hit,
  input  logic [IW-1:0]     hit_idx,
  input  logic [AW:0]       hit_lim,
  input  logic              s_awvalid,
  output logic              s_awready,
  output logic [NSLV-1:0]   m_awvalid,
  input  logic [NSLV-1:0]   m_awready,
  input  logic              s_wvalid,
  input  logic              s_wlast,
  output logic              s_wready,
  output logic [NSLV-1:0]   m_wvalid,
  input  logic [NSLV-1:0]   m_wready,
  input  logic [2*NSLV-1:0] m_bresp,
  input  logic [NSLV-1:0]   m_bvalid,
  output logic [NSLV-1:0]   m_bready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  output logic [IW-1:0]     dec_idx
);
  wr_state_e     st, st_nx;
  logic [IW-1:0] sel, sel_nx;
  logic          sel_en;
  logic          dflt;
  logic          aw_rdy_sel, w_rdy_sel, b_vld_sel;
  logic [1:0]    b_resp_sel;
  logic          aw_hs, w_last_hs, b_hs;

  assign dflt    = (sel == IW'(NSLV));
  assign dec_idx = sel;

  // per-port views of the handshake inputs
  always_comb begin
    aw_rdy_sel = 1'b1;
    w_rdy_sel  = 1'b1;
    b_vld_sel  = 1'b1;
    b_resp_sel = RESP_DECERR;
    for (int k = 0; k < NSLV; k++) begin
      if (hit && hit_idx == IW'(k)) aw_rdy_sel = m_awready[k];
      if (sel == IW'(k)) begin
        w_rdy_sel  = m_wready[k];
        b_vld_sel  = m_bvalid[k];
        b_resp_sel = m_bresp[2*k +: 2];
      end
    end
  end

  assign s_awready = (st == WR_IDLE) && aw_rdy_sel;
  assign s_wready  = (st == WR_DATA) && w_rdy_sel;
  assign s_bvalid  = (st == WR_RESP) && b_vld_sel;
  assign s_bresp   = b_resp_sel;

  assign aw_hs     = s_awvalid && s_awready;
  assign w_last_hs = s_wvalid && s_wready && s_wlast;
  assign b_hs      = s_bvalid && s_bready;

  for (genvar g = 0; g < NSLV; g++) begin : g_port
    assign m_awvalid[g] = (st == WR_IDLE) && s_awvalid && hit && (hit_idx == IW'(g));
    assign m_wvalid[g]  = (st == WR_DATA) && s_wvalid && (sel == IW'(g));
    assign m_bready[g]  = (st == WR_RESP) && s_bready && (sel == IW'(g));
  end

  always_comb begin
    st_nx  = st;
    sel_nx = sel;
    sel_en = 1'b0;
    case (st)
      WR_IDLE: if (aw_hs) begin
        st_nx  = WR_DATA;
        sel_nx = hit ? hit_idx : IW'(NSLV);
        sel_en = 1'b1;
      end
      WR_DATA: if (w_last_hs) st_nx = WR_RESP;
      WR_RESP: if (b_hs)      st_nx = WR_IDLE;
      default: st_nx = WR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= WR_IDLE;
      sel <= '0;
    end else begin
      st <= st_nx;
      if (sel_en) sel <= sel_nx;
    end
  end

  // R1: valid reaches at most one port, and only for an in-range address
  a_r1_aw_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(m_awvalid));
  a_r1_w_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(m_wvalid));
  a_r1_aw_inside: assert property (@(posedge clk) disable iff (!rst_n)
    (m_awvalid != '0) |-> ({1'b0, s_awaddr} < hit_lim));
  // R3: default responder answers the cycle after the last data beat
  a_r3_dflt_bresp: assert property (@(posedge clk) disable iff (!rst_n)
    (w_last_hs && dflt) |=> (s_bvalid && s_bresp == RESP_DECERR));
  // R8: no new write address while a response is pending
  a_r8_aw_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid |-> !s_awready);
endmodule

// File: rtl/axdec_rd_path.sv
module axdec_rd_path
  import axdec_pkg::*;
#(
  parameter int NSLV = 2,
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter int LW   = 8,
  parameter int IW   = $clog2(NSLV + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      s_araddr,
  input  logic [LW-1:0]      s_arlen,
  input  logic               hit,
  input  logic [IW-1:0]      hit_idx,
  input  logic [AW:0]        hit_lim,
  input  logic               s_arvalid,
  output logic               s_arready,
  output logic [NSLV-1:0]    m_arvalid,
  input  logic [NSLV-1:0]    m_arready,
  input  logic [DW*NSLV-1:0] m_rdata,
  input  logic [2*NSLV-1:0]  m_rresp,
  input  logic [NSLV-1:0]    m_rlast,
  input  logic [NSLV-1:0]    m_rvalid,
  output logic [NSLV-1:0]    m_rready,
  output logic [DW-1:0]      s_rdata,
  output logic [1:0]         s_rresp,
  output logic               s_rlast,
  output logic               s_rvalid,
  input  logic               s_rready,
  output logic [IW-1:0]      dec_idx
);
  localparam int BYTES = DW / 8;
  localparam logic [AW:0] STEP = (AW + 1)'(BYTES);

  rd_state_e     st, st_nx;
  logic [IW-1:0] sel, sel_nx;
  logic [AW:0]   lim, lim_nx;
  logic [AW:0]   baddr, baddr_nx;
  logic [LW-1:0] cnt, cnt_nx;
  logic [LW-1:0] len, len_nx;
  logic          ld_en, beat_en;
  logic          dflt, beyond, last;
  logic          ar_rdy_sel, r_vld_sel, r_last_sel;
  logic [DW-1:0] r_data_sel;
  logic [1:0]    r_resp_sel;
  logic          ar_hs, r_hs;

  assign dflt    = (sel == IW'(NSLV));
  assign dec_idx = sel;
  assign beyond  = (baddr >= lim);

  always_comb begin
    ar_rdy_sel = 1'b1;
    r_vld_sel  = 1'b0;
    r_last_sel = 1'b0;
    r_data_sel = '0;
    r_resp_sel = RESP_DECERR;
    for (int k = 0; k < NSLV; k++) begin
      if (hit && hit_idx == IW'(k)) ar_rdy_sel = m_arready[k];
      if (sel == IW'(k)) begin
        r_vld_sel  = m_rvalid[k];
        r_last_sel = m_rlast[k];
        r_data_sel = m_rdata[k*DW +: DW];
        r_resp_sel = m_rresp[2*k +: 2];
      end
    end
  end

  // beats past the selected region are overridden to a decode error
  assign last      = dflt ? (cnt == len) : r_last_sel;
  assign s_arready = (st == RD_IDLE) && ar_rdy_sel;
  assign s_rvalid  = (st == RD_DATA) && (dflt || r_vld_sel);
  assign s_rdata   = (dflt || beyond) ? '0 : r_data_sel;
  assign s_rresp   = (dflt || beyond) ? RESP_DECERR : r_resp_sel;
  assign s_rlast   = (st == RD_DATA) && last;

  assign ar_hs = s_arvalid && s_arready;
  assign r_hs  = s_rvalid && s_rready;

  for (genvar g = 0; g < NSLV; g++) begin : g_port
    assign m_arvalid[g] = (st == RD_IDLE) && s_arvalid && hit && (hit_idx == IW'(g));
    assign m_rready[g]  = (st == RD_DATA) && s_rready && (sel == IW'(g));
  end

  always_comb begin
    st_nx    = st;
    sel_nx   = sel;
    lim_nx   = lim;
    baddr_nx = baddr;
    cnt_nx   = cnt;
    len_nx   = len;
    ld_en    = 1'b0;
    beat_en  = 1'b0;
    case (st)
      RD_IDLE: if (ar_hs) begin
        st_nx    = RD_DATA;
        sel_nx   = hit ? hit_idx : IW'(NSLV);
        lim_nx   = hit_lim;
        baddr_nx = {1'b0, s_araddr};
        cnt_nx   = '0;
        len_nx   = s_arlen;
        ld_en    = 1'b1;
      end
      RD_DATA: if (r_hs) begin
        baddr_nx = baddr + STEP;
        cnt_nx   = cnt + 1'b1;
        beat_en  = 1'b1;
        if (last) st_nx = RD_IDLE;
      end
      default: st_nx = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= RD_IDLE;
      sel   <= '0;
      lim   <= '0;
      baddr <= '0;
      cnt   <= '0;
      len   <= '0;
    end else begin
      st <= st_nx;
      if (ld_en) begin
        sel <= sel_nx;
        lim <= lim_nx;
        len <= len_nx;
      end
      if (ld_en || beat_en) begin
        baddr <= baddr_nx;
        cnt   <= cnt_nx;
      end
    end
  end

  // R1: read valid to at most one port, only for an in-range address
  a_r1_ar_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(m_arvalid));
  a_r1_ar_inside: assert property (@(posedge clk) disable iff (!rst_n)
    (m_arvalid != '0) |-> ({1'b0, s_araddr} < hit_lim));
  // R4: nothing is returned after the beat marked last
  a_r4_no_extra_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (r_hs && s_rlast) |=> !s_rvalid);
  // R5: a success code is only ever seen inside the selected region
  a_r5_okay_inside: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rvalid && s_rresp == RESP_OKAY) |-> (!dflt && baddr < lim));
  // R10: a stalled default beat does not change
  a_r10_dflt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rvalid && !s_rready && dflt) |=>
      (s_rvalid && $stable(s_rdata) && $stable(s_rresp) && $stable(s_rlast)));
endmodule

// File: rtl/axi_addr_decoder.sv
module axi_addr_decoder #(
  parameter int NSLV = 2,
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter int LW   = 8,
  parameter logic [NSLV*AW-1:0] REGION_BASE = {16'h1800, 16'h1000},
  parameter logic [NSLV*AW-1:0] REGION_SIZE = {16'h1000, 16'h1000},
  localparam int IW  = $clog2(NSLV + 1),
  localparam int SW  = DW / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      s_awaddr,
  input  logic [LW-1:0]      s_awlen,
  input  logic               s_awvalid,
  output logic               s_awready,
  input  logic [DW-1:0]      s_wdata,
  input  logic [SW-1:0]      s_wstrb,
  input  logic               s_wlast,
  input  logic               s_wvalid,
  output logic               s_wready,
  output logic [1:0]         s_bresp,
  output logic               s_bvalid,
  input  logic               s_bready,
  input  logic [AW-1:0]      s_araddr,
  input  logic [LW-1:0]      s_arlen,
  input  logic               s_arvalid,
  output logic               s_arready,
  output logic [DW-1:0]      s_rdata,
  output logic [1:0]         s_rresp,
  output logic               s_rlast,
  output logic               s_rvalid,
  input  logic               s_rready,
  output logic [AW-1:0]      m_awaddr,
  output logic [LW-1:0]      m_awlen,
  output logic [NSLV-1:0]    m_awvalid,
  input  logic [NSLV-1:0]    m_awready,
  output logic [DW-1:0]      m_wdata,
  output logic [SW-1:0]      m_wstrb,
  output logic               m_wlast,
  output logic [NSLV-1:0]    m_wvalid,
  input  logic [NSLV-1:0]    m_wready,
  input  logic [2*NSLV-1:0]  m_bresp,
  input  logic [NSLV-1:0]    m_bvalid,
  output logic [NSLV-1:0]    m_bready,
  output logic [AW-1:0]      m_araddr,
  output logic [LW-1:0]      m_arlen,
  output logic [NSLV-1:0]    m_arvalid,
  input  logic [NSLV-1:0]    m_arready,
  input  logic [DW*NSLV-1:0] m_rdata,
  input  logic [2*NSLV-1:0]  m_rresp,
  input  logic [NSLV-1:0]    m_rlast,
  input  logic [NSLV-1:0]    m_rvalid,
  output logic [NSLV-1:0]    m_rready,
  output logic [IW-1:0]      wr_dec_idx,
  output logic [IW-1:0]      rd_dec_idx
);
  logic          aw_hit, ar_hit;
  logic [IW-1:0] aw_idx, ar_idx;
  logic [AW:0]   aw_lim, ar_lim;

  // payload is broadcast; only the valids are steered
  assign m_awaddr = s_awaddr;
  assign m_awlen  = s_awlen;
  assign m_wdata  = s_wdata;
  assign m_wstrb  = s_wstrb;
  assign m_wlast  = s_wlast;
  assign m_araddr = s_araddr;
  assign m_arlen  = s_arlen;

  axdec_region_match #(.NSLV(NSLV), .AW(AW), .IW(IW),
                       .BASES(REGION_BASE), .SIZES(REGION_SIZE)) u_aw_match (
    .addr(s_awaddr), .hit(aw_hit), .idx(aw_idx), .lim(aw_lim));

  axdec_region_match #(.NSLV(NSLV), .AW(AW), .IW(IW),
                       .BASES(REGION_BASE), .SIZES(REGION_SIZE)) u_ar_match (
    .addr(s_araddr), .hit(ar_hit), .idx(ar_idx), .lim(ar_lim));

  axdec_wr_path #(.NSLV(NSLV), .AW(AW), .IW(IW)) u_wr (
    .clk(clk), .rst_n(rst_n), .s_awaddr(s_awaddr),
    .hit(aw_hit), .hit_idx(aw_idx), .hit_lim(aw_lim),
    .s_awvalid(s_awvalid), .s_awready(s_awready),
    .m_awvalid(m_awvalid), .m_awready(m_awready),
    .s_wvalid(s_wvalid), .s_wlast(s_wlast), .s_wready(s_wready),
    .m_wvalid(m_wvalid), .m_wready(m_wready),
    .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .dec_idx(wr_dec_idx));

  axdec_rd_path #(.NSLV(NSLV), .AW(AW), .DW(DW), .LW(LW), .IW(IW)) u_rd (
    .clk(clk), .rst_n(rst_n), .s_araddr(s_araddr), .s_arlen(s_arlen),
    .hit(ar_hit), .hit_idx(ar_idx), .hit_lim(ar_lim),
    .s_arvalid(s_arvalid), .s_arready(s_arready),
    .m_arvalid(m_arvalid), .m_arready(m_arready),
    .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rlast(m_rlast),
    .m_rvalid(m_rvalid), .m_rready(m_rready),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rlast(s_rlast),
    .s_rvalid(s_rvalid), .s_rready(s_rready),
    .dec_idx(rd_dec_idx));
endmodule

// File: tb/tb_axi_addr_decoder.sv
module tb_axi_addr_decoder;
  localparam int NS = 2;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int LW = 8;
  localparam int IW = $clog2(NS + 1);
  localparam int BASE [NS] = '{32'h1000, 32'h1800};
  localparam int SIZE [NS] = '{32'h1000, 32'h1000};

  logic clk = 1'b0;
  logic rst_n;
  always #4 clk = ~clk;

  logic [AW-1:0] s_awaddr, s_araddr, m_awaddr, m_araddr;
  logic [LW-1:0] s_awlen, s_arlen, m_awlen, m_arlen;
  logic s_awvalid, s_awready, s_wlast, s_wvalid, s_wready, s_bvalid, s_bready;
  logic s_arvalid, s_arready, s_rlast, s_rvalid, s_rready, m_wlast;
  logic [DW-1:0] s_wdata, s_rdata, m_wdata;
  logic [DW/8-1:0] s_wstrb, m_wstrb;
  logic [1:0] s_bresp, s_rresp;
  logic [NS-1:0] m_awvalid, m_awready, m_wvalid, m_wready, m_bvalid, m_bready;
  logic [NS-1:0] m_arvalid, m_arready, m_rlast, m_rvalid, m_rready;
  logic [2*NS-1:0] m_bresp, m_rresp;
  logic [DW*NS-1:0] m_rdata;
  logic [IW-1:0] wr_dec_idx, rd_dec_idx;

  axi_addr_decoder dut (.*);

  int total = 0;
  int bad = 0;
  int cur_widx = NS;
  bit mon_on = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int lookup(input int a);
    for (int k = 0; k < NS; k++)
      if (a >= BASE[k] && a < BASE[k] + SIZE[k]) return k;
    return NS;
  endfunction

  // behavioural subordinates: always ready, port 1 answers writes with 2'b10
  logic [NS-1:0] sb_v, sr_v;
  int sr_cnt [NS];
  int sr_len [NS];
  assign m_awready = '1;
  assign m_wready  = '1;
  assign m_arready = '1;
  assign m_bvalid  = sb_v;
  assign m_rvalid  = sr_v;
  assign m_bresp   = {2'b10, 2'b00};
  assign m_rresp   = '0;
  always_comb begin
    for (int k = 0; k < NS; k++) begin
      m_rdata[k*DW +: DW] = {8'(k), 16'h0, 8'(sr_cnt[k])};
      m_rlast[k] = sr_v[k] && (sr_cnt[k] == sr_len[k]);
    end
  end
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sb_v <= '0;
      sr_v <= '0;
      for (int k = 0; k < NS; k++) begin sr_cnt[k] <= 0; sr_len[k] <= 0; end
    end else begin
      for (int k = 0; k < NS; k++) begin
        if (sb_v[k] && m_bready[k]) sb_v[k] <= 1'b0;
        if (m_wvalid[k] && m_wlast) sb_v[k] <= 1'b1;
        if (sr_v[k] && m_rready[k]) begin
          if (sr_cnt[k] == sr_len[k]) sr_v[k] <= 1'b0;
          else sr_cnt[k] <= sr_cnt[k] + 1;
        end
        if (m_arvalid[k]) begin
          sr_v[k] <= 1'b1; sr_cnt[k] <= 0; sr_len[k] <= int'(m_arlen);
        end
      end
    end
  end

  // per-clock routing model (R1, R2)
  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      logic [NS-1:0] e_aw, e_ar, e_w;
      int ia, ir;
      #2;
      ia = lookup(int'(s_awaddr));
      ir = lookup(int'(s_araddr));
      e_aw = (s_awvalid && ia < NS) ? NS'(1 << ia) : '0;
      e_ar = (s_arvalid && ir < NS) ? NS'(1 << ir) : '0;
      e_w  = (s_wvalid && cur_widx < NS) ? NS'(1 << cur_widx) : '0;
      chk(m_awvalid == e_aw, "R1", "m_awvalid", m_awvalid, e_aw);
      chk(m_arvalid == e_ar, "R1", "m_arvalid", m_arvalid, e_ar);
      chk(m_wvalid == e_w, "R1", "m_wvalid", m_wvalid, e_w);
    end
  end

  task automatic do_wr(input int a, input int len, input string tag);
    int idx = lookup(a);
    int eb = (idx == NS) ? 3 : ((idx == 1) ? 2 : 0);
    s_awaddr = AW'(a); s_awlen = LW'(len); s_awvalid = 1'b1;
    #1;
    while (!s_awready) begin @(negedge clk); #1; end
    @(negedge clk); s_awvalid = 1'b0; cur_widx = idx; #1;
    chk(int'(wr_dec_idx) == idx, "R7", {tag, " wr_dec_idx"}, wr_dec_idx, idx);
    chk(s_awready == 1'b0, "R8", "awready during data", s_awready, 0);
    for (int i = 0; i <= len; i++) begin
      s_wdata = DW'(32'hA000 + i); s_wstrb = '1; s_wlast = (i == len); s_wvalid = 1'b1;
      #1;
      while (!s_wready) begin @(negedge clk); #1; end
      @(negedge clk);
    end
    s_wvalid = 1'b0; s_wlast = 1'b0; cur_widx = NS; #1;
    chk(s_bvalid == 1'b1, (idx == NS) ? "R3" : "R6", {tag, " bvalid timing"}, s_bvalid, 1);
    chk(int'(s_bresp) == eb, (idx == NS) ? "R3" : "R6", {tag, " bresp"}, s_bresp, eb);
    chk(s_awready == 1'b0, "R8", "awready while B pending", s_awready, 0);
    @(negedge clk); #1;
    chk(s_bvalid == 1'b1, "R3", {tag, " bvalid held"}, s_bvalid, 1);
    s_bready = 1'b1;
    @(negedge clk); s_bready = 1'b0; #1;
    chk(s_bvalid == 1'b0, "R3", {tag, " single B"}, s_bvalid, 0);
  endtask

  task automatic do_rd(input int a, input int len, input int stall, input string tag);
    int idx = lookup(a);
    int lim = (idx < NS) ? BASE[idx] + SIZE[idx] : 0;
    s_araddr = AW'(a); s_arlen = LW'(len); s_arvalid = 1'b1; s_rready = 1'b1;
    #1;
    while (!s_arready) begin @(negedge clk); #1; end
    @(negedge clk); s_arvalid = 1'b0; #1;
    chk(int'(rd_dec_idx) == idx, "R7", {tag, " rd_dec_idx"}, rd_dec_idx, idx);
    chk(s_arready == 1'b0, "R8", "arready during burst", s_arready, 0);
    chk(s_rvalid == 1'b1, "R4", {tag, " first beat timing"}, s_rvalid, 1);
    for (int i = 0; i <= len; i++) begin
      int ba = a + i * (DW / 8);
      bit err = (idx == NS) || (ba >= lim);
      logic [DW-1:0] ed = err ? '0 : {8'(idx), 16'h0, 8'(i)};
      logic [1:0] er = err ? 2'b11 : 2'b00;
      while (!s_rvalid) begin @(negedge clk); #1; end
      if (i == stall) begin
        logic [DW-1:0] hd = s_rdata;
        s_rready = 1'b0;
        @(negedge clk); #1;
        chk(s_rvalid && s_rdata == hd, "R10", {tag, " stalled beat"}, s_rdata, hd);
        s_rready = 1'b1;
      end
      chk(s_rresp == er, (idx == NS) ? "R4" : "R5", {tag, " rresp"}, s_rresp, er);
      chk(s_rdata == ed, (idx == NS) ? "R4" : "R5", {tag, " rdata"}, s_rdata, ed);
      chk(s_rlast == (i == len), "R4", {tag, " rlast"}, s_rlast, (i == len));
      @(negedge clk); #1;
    end
    chk(s_rvalid == 1'b0, "R4", {tag, " no extra beat"}, s_rvalid, 0);
  endtask

  initial begin
    #(8 * 100000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    s_awaddr = '0; s_awlen = '0; s_awvalid = 1'b0;
    s_wdata = '0; s_wstrb = '0; s_wlast = 1'b0; s_wvalid = 1'b0; s_bready = 1'b0;
    s_araddr = '0; s_arlen = '0; s_arvalid = 1'b0; s_rready = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(s_bvalid == 1'b0 && s_rvalid == 1'b0, "R9", "reset valids", {s_bvalid, s_rvalid}, 0);
    chk(m_awvalid == '0 && m_arvalid == '0, "R9", "reset port valids", {m_awvalid, m_arvalid}, 0);
    @(negedge clk); rst_n = 1'b1; mon_on = 1'b1;
    @(negedge clk);

    do_wr(32'h1100, 1, "R1 wr port0");
    do_wr(32'h1900, 0, "R2 wr overlap");
    do_wr(32'h2400, 2, "R6 wr port1");
    do_wr(32'h5000, 3, "R3 wr unmapped");
    do_wr(32'h0000, 0, "R3 wr low unmapped");
    do_rd(32'h1000, 3, -1, "R1 rd port0");
    do_rd(32'h1A00, 1, -1, "R2 rd overlap");
    do_rd(32'h0100, 2, 1, "R4 rd unmapped");
    do_rd(32'h27F8, 3, -1, "R5 rd cross to gap");
    do_rd(32'h1FFC, 1, -1, "R5 rd cross region end");
    do_rd(32'h9000, 0, 0, "R4 rd single beat");

    mon_on = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule